// File: doc/BRIEF.md
# LCD raster timing generator

This block produces the timing skeleton of a raster LCD panel. A divided pixel strobe is taken from the system clock. Horizontal and vertical scan counters advance on that strobe, and the block decodes line sync, frame sync and an active-video window from the counters. Software programs four packed configuration words through a simple write port. The words hold the clock divisor, the horizontal and vertical geometry, and the polarity and sync-edge controls. Software then sets the raster enable input.

The downstream pixel pipeline uses the pixel strobe, the active-video flag and the two scan counters to decide when to present data. The panel pins take the pixel clock, the line clock and the frame clock, each after an optional inversion. Line width is coded in groups of 16 pixels. When the extended-geometry parameter is set, both the width code and the line count have one additional high bit, each placed in a separate location.

Top module: `lcd_raster_timing`

## Requirements
- R1: The divisor is bits 15:8 of word 0 (wr_sel=0). Its effective value N is that field limited to the range 2 to 255, so the values 0 and 1 give N=2. When running, pix_stb is a one-cycle pulse every N clocks. In each pixel period pix_clk (before inversion) is low for the first floor(N/2) clocks and high for the remaining clocks.
- R2: Word 1 (wr_sel=1) sets the horizontal geometry: back porch minus one in bits 31:24, front porch minus one in bits 23:16, sync width minus one in bits 15:10, and the width code P in bits 9:4. A line has (P+1)*16 active pixels and runs sync, back porch, active, front porch. pixel_count is 0 on the first sync pixel and reaches the line total minus one.
- R3: With EXT_MODE=1, bit 3 of word 1 is bit 6 of the width code P.
- R4: Word 2 (wr_sel=2) sets the vertical geometry: back porch minus one in bits 31:24, front porch minus one in bits 23:16, sync width minus one in bits 15:10, and lines minus one in bits 9:0. A frame runs sync lines, back porch, active lines, front porch. line_count advances only when pixel_count wraps to 0.
- R5: With EXT_MODE=1, bit 26 of word 3 (wr_sel=3) is bit 10 of the lines-minus-one value.
- R6: active_video is high only while both counters are inside their active regions. The first active pixel has pixel_count equal to hsync width plus horizontal back porch, and line_count equal to vsync width plus vertical back porch. A frame holds exactly pixels times lines active strobes.
- R7: Bits 22, 21 and 20 of word 3 invert pix_clk, line_clk and frame_clk. Without inversion the syncs are high during their sync regions.
- R8: Setting bit 25 of word 3 enables edge selection. With bit 25 set, bit 24 = 1 makes line_clk and frame_clk change floor(N/2) clocks after the counters, on the rising pixel-clock edge. In every other case the syncs change in the same clock as the counters.
- R9: While raster_en is low, both counters are 0, pix_stb and active_video are 0, and pix_clk, line_clk and frame_clk sit at their inactive (inversion-only) level. After raster_en rises, the frame starts at pixel 0 of line 0 with line sync active, and the first pix_stb comes in the N-th clock.
- R10: A synchronous active-low reset clears all configuration and scan state, so every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Configuration word select (0 divisor, 1 horizontal, 2 vertical, 3 polarity/edge) |
| wr_data | input | 32 | Configuration write data |
| raster_en | input | 1 | Run the scan when high, hold at frame start when low |
| pix_stb | output | 1 | One-cycle pulse per pixel period |
| pix_clk | output | 1 | Pixel clock after optional inversion |
| line_clk | output | 1 | Line sync after optional inversion |
| frame_clk | output | 1 | Frame sync after optional inversion |
| active_video | output | 1 | High on pixels inside the active window |
| pixel_count | output | 12 | Current pixel position in the line, 0 at sync start |
| line_count | output | 12 | Current line position in the frame, 0 at sync start |

## Verification
A divider fault appears within one pixel period as a strobe gap or a pixel-clock duty cycle that differs from the clamped divisor. A counter wrap or region-boundary fault appears within one line or one frame, as a wrong strobe count between returns to pixel 0 line 0, a shifted first active position, or a wrong sync width. Polarity and edge-select faults appear at once, in the idle output level or in the clock offset between a counter change and a sync change. The bench runs whole frames for several geometries, including both extended high bits, so every such fault is caught within its first frame.

// File: rtl/lcd_tg_pkg.sv
// Package: shared widths and the decoded timing configuration record.
// Assumes every scan count fits CNT_W bits (porches and syncs up to 256, line up to 2048).
package lcd_tg_pkg;
    parameter int unsigned DIV_W      = 8;   // divisor field width
    parameter int unsigned CNT_W      = 12;  // scan counter width
    parameter int unsigned PORCH_W    = 8;   // porch field width
    parameter int unsigned SYNC_W     = 6;   // sync width field width
    parameter int unsigned PPL_LO_W   = 6;   // base width code bits
    parameter int unsigned LPP_LO_W   = 10;  // base line code bits
    parameter int unsigned PPL_UNIT_SH = 4;  // width code unit is 16 pixels

    typedef struct packed {
        logic [DIV_W-1:0] div_eff;
        logic [CNT_W-1:0] hsw;
        logic [CNT_W-1:0] hbp;
        logic [CNT_W-1:0] ppl;
        logic [CNT_W-1:0] hfp;
        logic [CNT_W-1:0] vsw;
        logic [CNT_W-1:0] vbp;
        logic [CNT_W-1:0] lines;
        logic [CNT_W-1:0] vfp;
        logic             inv_pix;
        logic             inv_line;
        logic             inv_frame;
        logic             edge_sel_en;
        logic             edge_rise;
    } tg_cfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
// Module: configuration word store and field decoder.
// Holds only the fields the timing logic uses, converts the coded fields into real counts
// and raises the divisor to its floor. EXT_MODE adds the extra width and line-count bits.
module lcd_tg_regs
    import lcd_tg_pkg::*;
#(
    parameter bit          EXT_MODE = 1'b1,
    parameter int unsigned DIV_MIN  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output tg_cfg_t     cfg
);
    localparam logic [1:0] SEL_DIV  = 2'd0;
    localparam logic [1:0] SEL_HORZ = 2'd1;
    localparam logic [1:0] SEL_VERT = 2'd2;
    localparam logic [1:0] SEL_MISC = 2'd3;
    localparam int unsigned PPL_W = PPL_LO_W + 1;
    localparam int unsigned LPP_W = LPP_LO_W + 1;

    logic [DIV_W-1:0]    div_f;
    logic [PORCH_W-1:0]  hbp_f, hfp_f, vbp_f, vfp_f;
    logic [SYNC_W-1:0]   hsw_f, vsw_f;
    logic [PPL_LO_W-1:0] ppl_lo;
    logic [LPP_LO_W-1:0] lpp_lo;
    logic                ppl_hi, lpp_hi;
    logic                inv_p, inv_l, inv_f, esel, erise;

    // Base field storage written through the select port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_f <= '0; hbp_f <= '0; hfp_f <= '0; hsw_f <= '0; ppl_lo <= '0;
            vbp_f <= '0; vfp_f <= '0; vsw_f <= '0; lpp_lo <= '0;
            inv_p <= 1'b0; inv_l <= 1'b0; inv_f <= 1'b0; esel <= 1'b0; erise <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_DIV:  div_f <= wr_data[15:8];
                SEL_HORZ: begin
                    hbp_f  <= wr_data[31:24];
                    hfp_f  <= wr_data[23:16];
                    hsw_f  <= wr_data[15:10];
                    ppl_lo <= wr_data[9:4];
                end
                SEL_VERT: begin
                    vbp_f  <= wr_data[31:24];
                    vfp_f  <= wr_data[23:16];
                    vsw_f  <= wr_data[15:10];
                    lpp_lo <= wr_data[9:0];
                end
                SEL_MISC: begin
                    esel  <= wr_data[25];
                    erise <= wr_data[24];
                    inv_p <= wr_data[22];
                    inv_l <= wr_data[21];
                    inv_f <= wr_data[20];
                end
                default: ;
            endcase
        end
    end

    generate
        if (EXT_MODE) begin : g_ext
            logic ppl_hi_q, lpp_hi_q;
            // Extended high bits of the width and line codes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ppl_hi_q <= 1'b0;
                    lpp_hi_q <= 1'b0;
                end else if (wr_en) begin
                    if (wr_sel == SEL_HORZ) ppl_hi_q <= wr_data[3];
                    if (wr_sel == SEL_MISC) lpp_hi_q <= wr_data[26];
                end
            end
            assign ppl_hi = ppl_hi_q;
            assign lpp_hi = lpp_hi_q;
        end else begin : g_base
            assign ppl_hi = 1'b0;
            assign lpp_hi = 1'b0;
        end
    endgenerate

    logic [PPL_W-1:0] ppl_code;
    logic [LPP_W-1:0] lpp_code;
    assign ppl_code = {ppl_hi, ppl_lo};
    assign lpp_code = {lpp_hi, lpp_lo};

    // Field decode: coded minus-one values become real counts, divisor gets its floor.
    always_comb begin
        cfg.div_eff     = (div_f < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_f;
        cfg.hsw         = CNT_W'(hsw_f) + CNT_W'(1);
        cfg.hbp         = CNT_W'(hbp_f) + CNT_W'(1);
        cfg.hfp         = CNT_W'(hfp_f) + CNT_W'(1);
        cfg.ppl         = (CNT_W'(ppl_code) + CNT_W'(1)) << PPL_UNIT_SH;
        cfg.vsw         = CNT_W'(vsw_f) + CNT_W'(1);
        cfg.vbp         = CNT_W'(vbp_f) + CNT_W'(1);
        cfg.vfp         = CNT_W'(vfp_f) + CNT_W'(1);
        cfg.lines       = CNT_W'(lpp_code) + CNT_W'(1);
        cfg.inv_pix     = inv_p;
        cfg.inv_line    = inv_l;
        cfg.inv_frame   = inv_f;
        cfg.edge_sel_en = esel;
        cfg.edge_rise   = erise;
    end
endmodule

// File: rtl/lcd_tg_pixdiv.sv
// Module: pixel clock divider.
// Counts system clocks modulo the effective divisor while running. Gives an end-of-pixel
// strobe, a mid-pixel strobe one clock before the pixel clock rises, and the raw pixel clock.
// Assumes div_eff >= 2. The first period after enable is a full one.
module lcd_tg_pixdiv
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raster_en,
    input  logic [DIV_W-1:0] div_eff,
    output logic             running,
    output logic             pix_stb,
    output logic             mid_stb,
    output logic             pclk_raw
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] last;

    assign half = div_eff >> 1;
    assign last = div_eff - DIV_W'(1);

    // Run flag and divide counter, both held clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !raster_en) begin
            running <= 1'b0;
            cnt     <= '0;
        end else begin
            running <= 1'b1;
            if (running) cnt <= (cnt >= last) ? '0 : cnt + DIV_W'(1);
        end
    end

    // Strobe and raw pixel clock decode.
    always_comb begin
        pix_stb  = running && (cnt >= last);
        mid_stb  = running && (cnt == half - DIV_W'(1));
        pclk_raw = running && (cnt >= half);
    end
endmodule

// File: rtl/lcd_tg_scan.sv
// Module: horizontal and vertical scan counters with region decode.
// The pixel counter advances on each pixel strobe and wraps at the line total. The line
// counter advances on each wrap. Gives syncs that follow the counters directly, copies of the
// syncs taken at mid-pixel, and the active window. Assumes the configuration is stable
// while running.
module lcd_tg_scan
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raster_en,
    input  logic             running,
    input  logic             pix_stb,
    input  logic             mid_stb,
    input  logic [CNT_W-1:0] hsw,
    input  logic [CNT_W-1:0] hbp,
    input  logic [CNT_W-1:0] ppl,
    input  logic [CNT_W-1:0] hfp,
    input  logic [CNT_W-1:0] vsw,
    input  logic [CNT_W-1:0] vbp,
    input  logic [CNT_W-1:0] lines,
    input  logic [CNT_W-1:0] vfp,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] vcnt,
    output logic             hs_now,
    output logic             vs_now,
    output logic             hs_mid,
    output logic             vs_mid,
    output logic             de
);
    logic [CNT_W-1:0] h_a0, h_a1, h_last;
    logic [CNT_W-1:0] v_a0, v_a1, v_last;
    logic             h_act, v_act;

    // Region boundaries from the decoded counts.
    always_comb begin
        h_a0   = hsw + hbp;
        h_a1   = h_a0 + ppl;
        h_last = h_a1 + hfp - CNT_W'(1);
        v_a0   = vsw + vbp;
        v_a1   = v_a0 + lines;
        v_last = v_a1 + vfp - CNT_W'(1);
    end

    // Scan counters: pixel per strobe, line per pixel wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !raster_en) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (pix_stb) begin
            if (hcnt >= h_last) begin
                hcnt <= '0;
                vcnt <= (vcnt >= v_last) ? '0 : vcnt + CNT_W'(1);
            end else begin
                hcnt <= hcnt + CNT_W'(1);
            end
        end
    end

    // Region decode on the live counters.
    always_comb begin
        hs_now = running && (hcnt < hsw);
        vs_now = running && (vcnt < vsw);
        h_act  = (hcnt >= h_a0) && (hcnt < h_a1);
        v_act  = (vcnt >= v_a0) && (vcnt < v_a1);
        de     = running && h_act && v_act;
    end

    // Sync copies taken at mid-pixel for the rising-edge drive mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !raster_en) begin
            hs_mid <= 1'b0;
            vs_mid <= 1'b0;
        end else if (mid_stb) begin
            hs_mid <= hs_now;
            vs_mid <= vs_now;
        end
    end
endmodule

// File: rtl/lcd_raster_timing.sv
// Module: top of the raster timing generator.
// Joins the configuration store, the pixel divider and the scan counters. Picks the sync
// drive edge and applies the output polarity. Assumes software writes the geometry
// while raster_en is low.
module lcd_raster_timing
    import lcd_tg_pkg::*;
#(
    parameter bit          EXT_MODE = 1'b1,
    parameter int unsigned DIV_MIN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             raster_en,
    output logic             pix_stb,
    output logic             pix_clk,
    output logic             line_clk,
    output logic             frame_clk,
    output logic             active_video,
    output logic [CNT_W-1:0] pixel_count,
    output logic [CNT_W-1:0] line_count
);
    tg_cfg_t cfg;
    logic    running, mid_stb, pclk_raw;
    logic    hs_now, vs_now, hs_mid, vs_mid;
    logic    rise_mode;

    lcd_tg_regs #(.EXT_MODE(EXT_MODE), .DIV_MIN(DIV_MIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg(cfg)
    );

    lcd_tg_pixdiv u_div (
        .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .div_eff(cfg.div_eff),
        .running(running), .pix_stb(pix_stb), .mid_stb(mid_stb), .pclk_raw(pclk_raw)
    );

    lcd_tg_scan u_scan (
        .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .running(running),
        .pix_stb(pix_stb), .mid_stb(mid_stb),
        .hsw(cfg.hsw), .hbp(cfg.hbp), .ppl(cfg.ppl), .hfp(cfg.hfp),
        .vsw(cfg.vsw), .vbp(cfg.vbp), .lines(cfg.lines), .vfp(cfg.vfp),
        .hcnt(pixel_count), .vcnt(line_count),
        .hs_now(hs_now), .vs_now(vs_now), .hs_mid(hs_mid), .vs_mid(vs_mid),
        .de(active_video)
    );

    // Edge selection and polarity at the panel pins.
    always_comb begin
        rise_mode = cfg.edge_sel_en && cfg.edge_rise;
        pix_clk   = pclk_raw ^ cfg.inv_pix;
        line_clk  = (rise_mode ? hs_mid : hs_now) ^ cfg.inv_line;
        frame_clk = (rise_mode ? vs_mid : vs_now) ^ cfg.inv_frame;
    end
endmodule

// File: rtl/lcd_tg_checker.sv
// Module: property checker bound to the timing generator top.
// Watches the strobe, the counters, the active window and the unmodified sync levels.
module lcd_tg_checker
    import lcd_tg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             raster_en,
    input logic             pix_stb,
    input logic             active_video,
    input logic [CNT_W-1:0] pixel_count,
    input logic [CNT_W-1:0] line_count,
    input logic             hs_now,
    input logic             vs_now
);
    p_stb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> !pix_stb);

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_en && !pix_stb) |=> $stable(pixel_count));

    p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        raster_en |=> ($stable(line_count) || pixel_count == '0));

    p_no_sync_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active_video |-> (!hs_now && !vs_now));

    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !raster_en |=> (pixel_count == '0 && line_count == '0 && !pix_stb && !active_video));
endmodule

bind lcd_raster_timing lcd_tg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .pix_stb(pix_stb),
    .active_video(active_video), .pixel_count(pixel_count), .line_count(line_count),
    .hs_now(hs_now), .vs_now(vs_now)
);

// File: tb/lcd_raster_timing_bench.sv
module lcd_raster_timing_bench;
    logic        clk = 1'b0;
    logic        rst_n, wr_en, raster_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        pix_stb, pix_clk, line_clk, frame_clk, active_video;
    logic [11:0] pixel_count, line_count;
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lcd_raster_timing u_lcd_raster_timing (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .raster_en(raster_en), .pix_stb(pix_stb), .pix_clk(pix_clk), .line_clk(line_clk),
        .frame_clk(frame_clk), .active_video(active_video),
        .pixel_count(pixel_count), .line_count(line_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); raster_en = 1'b0;
        @(negedge clk); raster_en = 1'b1;
    endtask

    task automatic wait_stb();
        do @(negedge clk); while (!pix_stb);
    endtask

    task automatic idle_levels(input string req, input int p, input int l, input int f);
        check(req, "pix_stb idle", pix_stb, 0);
        check(req, "active idle", active_video, 0);
        check(req, "pixel_count idle", pixel_count, 0);
        check(req, "line_count idle", line_count, 0);
        check(req, "pix_clk idle", pix_clk, p);
        check(req, "line_clk idle", line_clk, l);
        check(req, "frame_clk idle", frame_clk, f);
    endtask

    task automatic period(input string req, input int exp);
        int n;
        restart();
        wait_stb();
        n = 0;
        do begin @(negedge clk); n++; end while (!pix_stb);
        check(req, "strobe period", n, exp);
    endtask

    task automatic duty(input string req, input int div, input int exp_high);
        int h;
        restart();
        wait_stb();
        h = 0;
        repeat (div) begin @(negedge clk); if (pix_clk) h++; end
        check(req, "pix_clk high clocks", h, exp_high);
    endtask

    task automatic scan_frame(input string tag, input int hsw, input int hbp, input int ppl,
                              input int hfp, input int vsw, input int vbp, input int lines,
                              input int vfp, input bit il, input bit ifr);
        int htot, vtot, n, act, fs, hs, fpx, fln, mpx, mln;
        bit seen, done;
        htot = hsw + hbp + ppl + hfp;
        vtot = vsw + vbp + lines + vfp;
        restart();
        wait_stb();
        check({tag, " R9"}, "start pixel", pixel_count, 0);
        check({tag, " R9"}, "start line", line_count, 0);
        n = 0; act = 0; fs = 0; hs = 0; fpx = -1; fln = -1; mpx = 0; mln = 0;
        seen = 1'b0; done = 1'b0;
        while (!done) begin
            n++;
            if (active_video) begin
                act++;
                if (!seen) begin seen = 1'b1; fpx = pixel_count; fln = line_count; end
            end
            if (line_clk ^ il) hs++;
            if (frame_clk ^ ifr) fs++;
            if (int'(pixel_count) > mpx) mpx = pixel_count;
            if (int'(line_count) > mln) mln = line_count;
            wait_stb();
            if (pixel_count == 0 && line_count == 0) done = 1'b1;
        end
        check({tag, " R4"}, "strobes per frame", n, htot * vtot);
        check({tag, " R6"}, "active strobes", act, ppl * lines);
        check({tag, " R4"}, "frame sync strobes", fs, vsw * htot);
        check({tag, " R2"}, "line sync strobes", hs, hsw * vtot);
        check({tag, " R6"}, "first active pixel", fpx, hsw + hbp);
        check({tag, " R6"}, "first active line", fln, vsw + vbp);
        check({tag, " R2"}, "max pixel_count", mpx, htot - 1);
        check({tag, " R4"}, "max line_count", mln, vtot - 1);
    endtask

    task automatic edge_gap(input string req, input int exp);
        int prev, n;
        restart();
        prev = pixel_count;
        do begin
            prev = pixel_count;
            @(negedge clk);
        end while (!(pixel_count == 0 && prev != 0));
        n = 0;
        while (!line_clk) begin @(negedge clk); n++; end
        check(req, "sync lag clocks", n, exp);
    endtask

    // Geometry A: hsw2 hbp3 ppl16 hfp1 / vsw1 vbp2 lines4 vfp1
    localparam logic [31:0] HA = (32'd2 << 24) | (32'd0 << 16) | (32'd1 << 10);
    localparam logic [31:0] VA = (32'd1 << 24) | (32'd0 << 16) | (32'd0 << 10) | 32'd3;
    // Geometry B: hsw4 hbp1 ppl32 hfp3 / vsw2 vbp1 lines2 vfp3
    localparam logic [31:0] HB = (32'd0 << 24) | (32'd2 << 16) | (32'd3 << 10) | (32'd1 << 4);
    localparam logic [31:0] VB = (32'd0 << 24) | (32'd2 << 16) | (32'd1 << 10) | 32'd1;

    initial begin
        int n;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 32'd0; raster_en = 1'b0;
        repeat (3) @(negedge clk);
        idle_levels("R10", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_levels("R9", 0, 0, 0);

        wr(2'd0, 32'd2 << 8); wr(2'd1, HA); wr(2'd2, VA); wr(2'd3, 32'd0);
        scan_frame("A", 2, 3, 16, 1, 1, 2, 4, 1, 1'b0, 1'b0);

        period("R1 div2", 2);
        wr(2'd0, 32'd0 << 8); period("R1 div0 clamp", 2);
        wr(2'd0, 32'd1 << 8); period("R1 div1 clamp", 2);
        wr(2'd0, 32'd3 << 8); period("R1 div3", 3);
        wr(2'd0, 32'd255 << 8); period("R1 div255", 255);
        wr(2'd0, 32'd5 << 8); duty("R1 duty5", 5, 3);

        wr(2'd0, 32'd3 << 8); wr(2'd1, HB); wr(2'd2, VB);
        scan_frame("B", 4, 1, 32, 3, 2, 1, 2, 3, 1'b0, 1'b0);

        @(negedge clk); raster_en = 1'b0;
        wr(2'd3, 32'd7 << 20);
        @(negedge clk);
        idle_levels("R7", 1, 1, 1);
        scan_frame("B inverted R7", 4, 1, 32, 3, 2, 1, 2, 3, 1'b1, 1'b1);
        duty("R7 pix_clk inverted", 3, 1);

        wr(2'd0, 32'd4 << 8);
        wr(2'd3, (32'd1 << 25) | (32'd1 << 24)); edge_gap("R8 rising", 2);
        scan_frame("B rising R8", 4, 1, 32, 3, 2, 1, 2, 3, 1'b0, 1'b0);
        wr(2'd3, 32'd1 << 24); edge_gap("R8 bit24 only", 0);
        wr(2'd3, 32'd1 << 25); edge_gap("R8 falling", 0);

        wr(2'd3, 32'd0);
        restart();
        repeat (37) @(negedge clk);
        raster_en = 1'b0;
        @(negedge clk);
        idle_levels("R9 stop", 0, 0, 0);
        raster_en = 1'b1;
        @(negedge clk);
        check("R9", "line sync at start", line_clk, 1);
        check("R9", "pixel at start", pixel_count, 0);
        n = 1;
        while (!pix_stb) begin @(negedge clk); n++; end
        check("R9", "first strobe clock", n, 4);

        wr(2'd0, 32'd2 << 8);
        wr(2'd1, (32'd1 << 10) | (32'd1 << 3)); wr(2'd2, 32'd0);
        scan_frame("R3 wide", 2, 1, 1040, 1, 1, 1, 1, 1, 1'b0, 1'b0);

        wr(2'd1, 32'd0); wr(2'd2, 32'd0); wr(2'd3, 32'd1 << 26);
        scan_frame("R5 tall", 1, 1, 16, 1, 1, 1, 1025, 1, 1'b0, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule